// File: doc/BRIEF.md
# Programmable Chip-Select Area Decoder

This block maps a 32-bit bus address onto one of eight programmable address windows, called areas. Each area has two registers. The first holds a base address. The second is a control word that sets the window size, the data bus width and the longest burst allowed for the area. The block raises a one-hot hit vector for the winning area. It also presents that area's width and burst codes to an external bus controller, or a no-hit flag when no area claims the address.

The window size is a 4-bit code that picks how many upper address bits take part in the base comparison. The address bits below that boundary are ignored. Area 0 is the boot area. Out of reset it claims the entire 4 GB space, whatever its size code holds. This whole-space mode lasts until software first writes area 0's control word. Area 0's bus width is taken from an external mode input while reset is held, so the first fetches use the right width.

Configuration is written through a single-cycle write port, and a write lands on the next clock edge. The decode path is combinational from the address and the stored configuration.

Top module: `cs_area_decode`

## Requirements
- R1: Reset is synchronous and active-low (`rstN`). While it is held, every area gets base 0, size code 4'b1111 and burst code 2'b00. Area 0 is enabled and areas 1 to 7 are disabled. After reset, an address that area 0 does not decode gives `noHit`=1.
- R2: While reset is held, area 0's width code is loaded from `modeWidth`. Changes to `modeWidth` after reset have no effect.
- R3: After reset, area 0 hits every address from 0x00000000 to 0xFFFFFFFF until the first write to area 0's control word. Writes to area 0's base register do not end this mode.
- R4: For size code s (0 to 15), address bits [31:16+s] are compared with the same bits of the base, and bits [15+s:0] are ignored. So 4'b0000 gives a 64 KB window, 4'b0111 compares A[31:23] (8 MB), and 4'b1111 compares only A[31] (2048 MB).
- R5: When several areas hit, the lowest-numbered one wins. `csHit` has at most one bit set. `noHit` is 1 exactly when no area hits, and in that case `selWidth` and `selBurst` are 2'b00.
- R6: Control word layout: bits [3:0] hold the size code. Bits [5:4] hold the width code: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit. Bits [7:6] hold the burst code: 00 is single, 01 is 2 beats, 10 is 4 beats, 11 is 8 beats. Bit 8 is the enable. A disabled area never hits.
- R7: A control write whose width field is the reserved code 2'b11 leaves the area's stored width unchanged. The size, burst and enable fields of that same write are still taken.
- R8: Write port: `wrEn`=1 writes `wrData` into area `wrArea`. With `wrIsCtrl`=1 the control word is written, with 0 the base. The new value is used from the next clock edge. In the write cycle itself, the decode still uses the old configuration.
- R9: `selWidth` and `selBurst` carry the width and burst codes of the winning area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeWidth | input | 2 | Width code loaded into area 0 during reset |
| wrEn | input | 1 | Register write strobe |
| wrIsCtrl | input | 1 | 1 writes the control word, 0 writes the base |
| wrArea | input | 3 | Area index for the write |
| wrData | input | 32 | Write data |
| busAddr | input | 32 | Address to decode |
| csHit | output | 8 | One-hot hit of the winning area |
| noHit | output | 1 | No area claims the address |
| selWidth | output | 2 | Width code of the winning area |
| selBurst | output | 2 | Burst code of the winning area |

## Verification
A configuration write and a decode can fall in the same cycle. The sharpest case is the first control write to area 0, which ends whole-space mode while an address is being decoded. The bench provokes this by writing area 0's control word, or an overlapping area's control word, while it presents an address whose answer depends on that write. It then judges the write cycle against the old configuration and the following cycle against the new one, using a behavioural model that applies writes only at the clock edge.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  localparam int CS_NUM_AREAS = 8;
  localparam int CS_ADDR_W    = 32;
  localparam int CS_MIN_LOG2  = 16;   // window size of size code 0
  localparam int CS_AREA_IDX_W = $clog2(CS_NUM_AREAS);
  localparam int CS_SIZE_W    = 4;
  localparam int CS_CODE_W    = 2;

  // control word field positions
  localparam int CTRL_SIZE_LSB  = 0;
  localparam int CTRL_WIDTH_LSB = CTRL_SIZE_LSB + CS_SIZE_W;
  localparam int CTRL_BURST_LSB = CTRL_WIDTH_LSB + CS_CODE_W;
  localparam int CTRL_EN_BIT    = CTRL_BURST_LSB + CS_CODE_W;

  typedef enum logic [CS_CODE_W-1:0] {
    BUS_W8  = 2'b00,
    BUS_W16 = 2'b01,
    BUS_W32 = 2'b10,
    BUS_RSV = 2'b11
  } busWidth_e;

  typedef enum logic [CS_CODE_W-1:0] {
    BURST_1 = 2'b00,
    BURST_2 = 2'b01,
    BURST_4 = 2'b10,
    BURST_8 = 2'b11
  } burstLen_e;

  typedef struct packed {
    logic [CS_SIZE_W-1:0] sizeCode;
    busWidth_e            width;
    burstLen_e            burst;
    logic                 enable;
  } areaCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [CS_NUM_AREAS-1:0] baseWr;
    logic [CS_NUM_AREAS-1:0] ctrlWr;
    logic                    keepWidth;
    logic                    wholeSpace;
  } decStrobe_t;

endpackage

// File: rtl/cs_area_match.sv
module cs_area_match
  import cs_dec_pkg::*;
(
  input  logic [CS_ADDR_W-1:0] busAddr,
  input  logic [CS_ADDR_W-1:0] baseAddr,
  input  logic [CS_SIZE_W-1:0] sizeCode,
  input  logic                 enable,
  input  logic                 wholeSpace,
  output logic                 hit
);

  logic [CS_ADDR_W-1:0] cmpMask;
  logic [CS_ADDR_W-1:0] diffBits;

  always_comb begin
    for (int b = 0; b < CS_ADDR_W; b++) begin
      cmpMask[b] = (b >= CS_MIN_LOG2 + int'(sizeCode));
    end
  end

  assign diffBits = (busAddr ^ baseAddr) & cmpMask;
  assign hit      = enable && (wholeSpace || (diffBits == '0));

endmodule

// File: rtl/cs_dec_ctrl.sv
module cs_dec_ctrl
  import cs_dec_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     wrIsCtrl,
  input  logic [CS_AREA_IDX_W-1:0] wrArea,
  input  logic [CS_CODE_W-1:0]     wrWidthCode,
  output decStrobe_t               stb
);

  logic overrideQ;
  logic area0CtrlWr;

  assign area0CtrlWr = wrEn && wrIsCtrl && (wrArea == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrideQ <= 1'b1;
    end else if (area0CtrlWr) begin
      overrideQ <= 1'b0;
    end
  end

  always_comb begin
    stb            = '0;
    stb.keepWidth  = (wrWidthCode == BUS_RSV);
    stb.wholeSpace = overrideQ;
    if (wrEn) begin
      if (wrIsCtrl) stb.ctrlWr[wrArea] = 1'b1;
      else          stb.baseWr[wrArea] = 1'b1;
    end
  end

endmodule

// File: rtl/cs_dec_datapath.sv
module cs_dec_datapath
  import cs_dec_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CS_CODE_W-1:0]    modeWidth,
  input  logic [CS_ADDR_W-1:0]    wrData,
  input  decStrobe_t              stb,
  input  logic [CS_ADDR_W-1:0]    busAddr,
  output logic [CS_NUM_AREAS-1:0] csHit,
  output logic                    noHit,
  output logic [CS_CODE_W-1:0]    selWidth,
  output logic [CS_CODE_W-1:0]    selBurst
);

  logic [CS_ADDR_W-1:0]    baseQ [CS_NUM_AREAS];
  areaCfg_t                cfgQ  [CS_NUM_AREAS];
  logic [CS_NUM_AREAS-1:0] hitVec;

  always_ff @(posedge clk) begin
    for (int i = 0; i < CS_NUM_AREAS; i++) begin
      if (!rstN) begin
        baseQ[i]         <= '0;
        cfgQ[i].sizeCode <= '1;
        cfgQ[i].width    <= (i == 0) ? busWidth_e'(modeWidth) : BUS_W8;
        cfgQ[i].burst    <= BURST_1;
        cfgQ[i].enable   <= (i == 0);
      end else begin
        if (stb.baseWr[i]) baseQ[i] <= wrData;
        if (stb.ctrlWr[i]) begin
          cfgQ[i].sizeCode <= wrData[CTRL_SIZE_LSB +: CS_SIZE_W];
          cfgQ[i].burst    <= burstLen_e'(wrData[CTRL_BURST_LSB +: CS_CODE_W]);
          cfgQ[i].enable   <= wrData[CTRL_EN_BIT];
          if (!stb.keepWidth)
            cfgQ[i].width  <= busWidth_e'(wrData[CTRL_WIDTH_LSB +: CS_CODE_W]);
        end
      end
    end
  end

  for (genvar g = 0; g < CS_NUM_AREAS; g++) begin : gArea
    cs_area_match match_i (
      .busAddr    (busAddr),
      .baseAddr   (baseQ[g]),
      .sizeCode   (cfgQ[g].sizeCode),
      .enable     (cfgQ[g].enable),
      .wholeSpace ((g == 0) ? stb.wholeSpace : 1'b0),
      .hit        (hitVec[g])
    );
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    csHit    = '0;
    selWidth = '0;
    selBurst = '0;
    for (int i = 0; i < CS_NUM_AREAS; i++) begin
      if (hitVec[i] && !found) begin
        found    = 1'b1;
        csHit[i] = 1'b1;
        selWidth = cfgQ[i].width;
        selBurst = cfgQ[i].burst;
      end
    end
    noHit = !found;
  end

endmodule

// File: rtl/cs_area_decode.sv
module cs_area_decode
  import cs_dec_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CS_CODE_W-1:0]     modeWidth,
  input  logic                     wrEn,
  input  logic                     wrIsCtrl,
  input  logic [CS_AREA_IDX_W-1:0] wrArea,
  input  logic [CS_ADDR_W-1:0]     wrData,
  input  logic [CS_ADDR_W-1:0]     busAddr,
  output logic [CS_NUM_AREAS-1:0]  csHit,
  output logic                     noHit,
  output logic [CS_CODE_W-1:0]     selWidth,
  output logic [CS_CODE_W-1:0]     selBurst
);

  decStrobe_t stb;

  cs_dec_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrIsCtrl    (wrIsCtrl),
    .wrArea      (wrArea),
    .wrWidthCode (wrData[CTRL_WIDTH_LSB +: CS_CODE_W]),
    .stb         (stb)
  );

  cs_dec_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeWidth (modeWidth),
    .wrData    (wrData),
    .stb       (stb),
    .busAddr   (busAddr),
    .csHit     (csHit),
    .noHit     (noHit),
    .selWidth  (selWidth),
    .selBurst  (selBurst)
  );

endmodule

// File: rtl/cs_dec_chk.sv
module cs_dec_chk
  import cs_dec_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [CS_CODE_W-1:0]     modeWidth,
  input logic                     wrEn,
  input logic                     wrIsCtrl,
  input logic [CS_AREA_IDX_W-1:0] wrArea,
  input logic [CS_ADDR_W-1:0]     busAddr,
  input logic [CS_NUM_AREAS-1:0]  csHit,
  input logic                     noHit,
  input logic [CS_CODE_W-1:0]     selWidth,
  input logic [CS_CODE_W-1:0]     selBurst
);

  logic area0Touched;

  always_ff @(posedge clk) begin
    if (!rstN) area0Touched <= 1'b0;
    else if (wrEn && wrIsCtrl && wrArea == '0) area0Touched <= 1'b1;
  end

  // R5
  single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csHit) && (noHit == (csHit == '0)));

  // R5
  idle_codes_chk: assert property (@(posedge clk) disable iff (!rstN)
    noHit |-> (selWidth == '0 && selBurst == '0));

  // R3
  boot_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !area0Touched |-> csHit[0]);

  // R2
  mode_width_chk: assert property (@(posedge clk)
    ($rose(rstN) && !wrEn) |-> (selWidth == $past(modeWidth)));

  // R8
  hold_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn ##1 $stable(busAddr)) |-> ($stable(csHit) && $stable(selWidth) && $stable(selBurst)));

endmodule

bind cs_area_decode cs_dec_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .modeWidth (modeWidth),
  .wrEn      (wrEn),
  .wrIsCtrl  (wrIsCtrl),
  .wrArea    (wrArea),
  .busAddr   (busAddr),
  .csHit     (csHit),
  .noHit     (noHit),
  .selWidth  (selWidth),
  .selBurst  (selBurst)
);

// File: tb/cs_area_decode_tb.sv
module cs_area_decode_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeWidth = 2'b01;
  logic        wrEn = 1'b0;
  logic        wrIsCtrl = 1'b0;
  logic [2:0]  wrArea = '0;
  logic [31:0] wrData = '0;
  logic [31:0] busAddr = '0;
  logic [7:0]  csHit;
  logic        noHit;
  logic [1:0]  selWidth;
  logic [1:0]  selBurst;

  always #4 clk = ~clk;   // 125 MHz

  cs_area_decode dut_i (.*);

  // behavioural reference
  logic [31:0] mBase [8];
  int          mSize [8];
  int          mWidth [8];
  int          mBurst [8];
  bit          mEn [8];
  bit          mWhole;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin
        mBase[i] = 0; mSize[i] = 15; mBurst[i] = 0;
        mWidth[i] = (i == 0) ? int'(modeWidth) : 0;
        mEn[i] = (i == 0);
      end
      mWhole = 1;
    end else if (wrEn) begin
      if (!wrIsCtrl) mBase[wrArea] = wrData;
      else begin
        mSize[wrArea]  = int'(wrData[3:0]);
        mBurst[wrArea] = int'(wrData[7:6]);
        mEn[wrArea]    = wrData[8];
        if (wrData[5:4] != 2'b11) mWidth[wrArea] = int'(wrData[5:4]);
        if (wrArea == 0) mWhole = 0;
      end
    end
  end

  task automatic check(input string req);
    int win;
    logic [7:0] eHit;
    logic [1:0] eW, eB;
    logic eNo;
    win = -1;
    for (int i = 7; i >= 0; i--) begin
      if (mEn[i] && ((i == 0 && mWhole) ||
          ((busAddr >> (16 + mSize[i])) == (mBase[i] >> (16 + mSize[i])))))
        win = i;
    end
    eHit = (win < 0) ? 8'h0 : (8'h1 << win);
    eNo  = (win < 0);
    eW   = (win < 0) ? 2'b00 : 2'(mWidth[win]);
    eB   = (win < 0) ? 2'b00 : 2'(mBurst[win]);
    compared++;
    if (csHit !== eHit || noHit !== eNo || selWidth !== eW || selBurst !== eB) begin
      mismatched++;
      $display("FAIL %s addr=%h actual hit=%b no=%b w=%b b=%b expected hit=%b no=%b w=%b b=%b",
               req, busAddr, csHit, noHit, selWidth, selBurst, eHit, eNo, eW, eB);
    end
  endtask

  // drive at negedge, compare before the next posedge
  task automatic step(input string req, input logic [31:0] a,
                      input bit we = 0, input bit ctl = 0,
                      input int area = 0, input logic [31:0] d = 0);
    @(negedge clk);
    busAddr = a; wrEn = we; wrIsCtrl = ctl; wrArea = 3'(area); wrData = d;
    #2;
    check(req);
  endtask

  function automatic logic [31:0] ctrlWord(int sz, int w, int b, bit en);
    return {23'd0, en, 2'(b), 2'(w), 4'(sz)};
  endfunction

  task automatic doReset(input logic [1:0] mw);
    @(negedge clk);
    rstN = 0; modeWidth = mw; wrEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset(2'b01);
    // R1 R2 R3: boot window covers the whole space with mode width
    step("R1", 32'h0000_0000);
    step("R2", 32'hFFFF_FFFF);
    modeWidth = 2'b10;   // R2: ignored after reset
    step("R3", 32'h8000_0000);
    // R3: base write to area 0 keeps whole-space mode
    step("R3", 32'h1234_5678, 1, 0, 0, 32'h4000_0000);
    step("R3", 32'h1234_5678);
    // R6: area 1 at 0x1000_0000, 8 MB, 32-bit, 4 beats
    step("R6", 32'h1000_0000, 1, 0, 1, 32'h1000_0000);
    step("R6", 32'h1000_0000, 1, 1, 1, ctrlWord(7, 2, 2, 1));
    step("R5", 32'h1000_0000);               // area 0 still wins
    // R8: first area 0 control write, same-cycle decode uses old config
    step("R8", 32'h1000_0000, 1, 1, 0, ctrlWord(0, 0, 1, 1));
    step("R8", 32'h1000_0000);               // area 1 now
    step("R4", 32'h107F_FFFF);
    step("R4", 32'h1080_0000);               // no hit
    step("R4", 32'h4000_FFFF);               // area 0, 64 KB
    step("R4", 32'h4001_0000);
    // R4: size 1111 compares only A[31]
    step("R4", 32'h0, 1, 0, 2, 32'h8000_0000);
    step("R9", 32'hC000_0000, 1, 1, 2, ctrlWord(15, 1, 3, 1));
    step("R9", 32'hC000_0000);
    step("R4", 32'h7FFF_FFFF);
    // R7: reserved width rejected, size still taken
    step("R7", 32'h8000_0000, 1, 1, 2, ctrlWord(14, 3, 1, 1));
    step("R7", 32'h8000_0000);
    step("R7", 32'hC000_0000);
    // R5: overlap of area 3 over area 1, then disable area 1
    step("R5", 32'h1000_0000, 1, 0, 3, 32'h0000_0000);
    step("R5", 32'h1000_0000, 1, 1, 3, ctrlWord(13, 0, 0, 1));
    step("R5", 32'h1000_0000);
    step("R6", 32'h1000_0000, 1, 1, 1, ctrlWord(7, 2, 2, 0));
    step("R6", 32'h1000_0000);
    // mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, d;
      int ar;
      a = $urandom; d = $urandom; ar = $urandom_range(0, 7);
      if (n % 5 == 0) step("R8", a, 1, d[9], ar, {d[31:16], 7'd0, d[8:0]});
      else step("R4", a);
    end
    // second reset with a different mode width
    doReset(2'b10);
    step("R1", 32'h5555_0000);
    step("R2", 32'hAAAA_0000);
    step("R1", 32'h0, 1, 1, 0, ctrlWord(15, 2, 0, 0));
    step("R1", 32'h0);                       // everything disabled: no hit
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule